// File: doc/BRIEF.md
# BCD Stopwatch with Lap Memory

This block is an elapsed-time stopwatch built on a single clock. Time is held as six separate BCD digits: tens and units of hours, of minutes and of seconds. Each digit can feed a seven-segment decoder directly. The count moves forward by one second on each one-second enable pulse, but only while the watch is running.

One input pulse flips the watch between running and stopped. A second input pulse copies the displayed time into a bank of lap registers. Captures fill the slots in turn, and the slot after the last one is the first. A synchronous reset clears the time, the run state, every lap and the slot pointer.

All inputs are one-cycle pulses that are already synchronized and edge-detected. They act only as clock enables.

Top module: `bcd_stopwatch`

## Requirements
- R1: While `rst` is high at a clock edge, `time_bcd`, every lap slot and `running` become zero, and the next capture after reset lands in slot 0.
- R2: On an edge where `running` is 1 and `tick_1s` is 1, the time advances by exactly one second. With no tick, the time holds.
- R3: A `run_toggle` pulse inverts `running`. While `running` is 0, ticks leave the time unchanged.
- R4: The seconds-units digit (`time_bcd[3:0]`) wraps from 9 to 0 and increments the seconds-tens digit (`[7:4]`).
- R5: Seconds roll from 59 to 00 and carry one into the minutes-units digit (`[11:8]`).
- R6: Minutes roll from 59 to 00 and carry one into the hours-units digit (`[19:16]`). The hours-tens digit is `[23:20]`.
- R7: After hours-tens `HR_TENS_MAX`, hours-units 9, 59:59, the next tick returns the time to all zeros. With the default of 9, this is 99:59:59 to 00:00:00.
- R8: A `lap_capture` pulse stores the current time in the slot the pointer selects. Slot k appears at `lap_bank[k*24 +: 24]`. Successive captures use slots 0, 1, 2, 3 in that order.
- R9: The capture after the last slot (N_LAPS-1) overwrites slot 0. Captures do not change the running time.
- R10: When a capture and an advancing tick occur on the same edge, the stored lap holds the time from before the increment.
- R11: When a toggle and a tick occur on the same edge, the run state from before the edge decides whether the tick counts.
- R12: Every digit always holds a valid BCD value. The tens digits of seconds and minutes never exceed 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-second enable pulse |
| run_toggle | input | 1 | Start/stop pulse that inverts the run state |
| lap_capture | input | 1 | Pulse that stores the current time in the next lap slot |
| running | output | 1 | 1 while the watch counts |
| time_bcd | output | 24 | Live time: h10, h1, m10, m1, s10, s1 digits, four bits each, h10 at the top |
| lap_bank | output | N_LAPS*24 | Stored laps, slot k at bits k*24 and up |

## Verification
Directed runs of consecutive ticks cover each carry boundary: units 9, seconds 59, minutes 59, and the final hour wrap. These runs show whether each digit wraps at its own limit and passes its carry to the right neighbour. Ticks sent while stopped, and idle cycles while running, separate the enable gating from the counting itself.

A run of five captures shows the rotation order and the overwrite of slot 0. Captures and toggles placed on the same edge as a tick show which value is sampled, the one before or the one after the increment.

A long seeded random mix of ticks, toggles and captures is then compared each cycle with a bench model. That model holds the time as a plain count of seconds and converts it to digits only for the comparison.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int DIGITS = 6;
  localparam int DIG_W  = 4;
  localparam int TIME_W = DIGITS * DIG_W;

  typedef logic [DIG_W-1:0]  bcd_t;
  typedef logic [TIME_W-1:0] stamp_t;

  // Largest value of digit idx (0 = seconds units ... 5 = hours tens).
  function automatic int digit_limit(input int idx, input int hr_tens_max);
    case (idx)
      1, 3:    return 5;
      5:       return hr_tens_max;
      default: return 9;
    endcase
  endfunction

  // Next value of a digit that advances, wrapping above lim.
  function automatic bcd_t bcd_next(input bcd_t d, input bcd_t lim);
    return (d == lim) ? '0 : bcd_t'(d + 1'b1);
  endfunction
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
  import stopwatch_pkg::*;
#(
  parameter int LIMIT = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic step_in,
  output logic carry_out,
  output bcd_t value
);
  localparam bcd_t LIM = bcd_t'(LIMIT);

  bcd_t d_q;

  always_ff @(posedge clk) begin
    if (rst)          d_q <= '0;
    else if (step_in) d_q <= bcd_next(d_q, LIM);
  end

  assign carry_out = step_in && (d_q == LIM);
  assign value     = d_q;

  p_digit_bcd_r12: assert property (@(posedge clk) disable iff (rst)
    d_q <= LIM);

  p_digit_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    carry_out |=> (d_q == '0));
endmodule

// File: rtl/time_chain.sv
module time_chain
  import stopwatch_pkg::*;
#(
  parameter int HR_TENS_MAX = 9
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   advance,
  output stamp_t now
);
  logic [DIGITS:0] carry;
  assign carry[0] = advance;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    bcd_t dval;
    bcd_digit #(.LIMIT(digit_limit(i, HR_TENS_MAX))) u_digit (
      .clk       (clk),
      .rst       (rst),
      .step_in   (carry[i]),
      .carry_out (carry[i+1]),
      .value     (dval)
    );
    assign now[i*DIG_W +: DIG_W] = dval;
  end

  // Named wrap events for the assertions
  logic sec_wrap, min_wrap, full_wrap;
  assign sec_wrap  = carry[2];
  assign min_wrap  = carry[4];
  assign full_wrap = carry[DIGITS];

  p_sec_roll_r5: assert property (@(posedge clk) disable iff (rst)
    sec_wrap |=> (now[7:0] == 8'h00));

  p_min_roll_r6: assert property (@(posedge clk) disable iff (rst)
    min_wrap |=> (now[15:0] == 16'h0000));

  p_full_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    full_wrap |=> (now == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(now));
endmodule

// File: rtl/lap_bank.sv
module lap_bank
  import stopwatch_pkg::*;
#(
  parameter int N_LAPS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  stamp_t                   stamp,
  output logic [N_LAPS*TIME_W-1:0] slots
);
  localparam int PTR_W = (N_LAPS > 1) ? $clog2(N_LAPS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_LAPS - 1);

  logic [PTR_W-1:0] ptr_q;
  stamp_t           slot_q [N_LAPS];

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (capture) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar k = 0; k < N_LAPS; k++) begin : g_slot
    logic wr_en;
    assign wr_en = capture && (ptr_q == PTR_W'(k));
    always_ff @(posedge clk) begin
      if (rst)        slot_q[k] <= '0;
      else if (wr_en) slot_q[k] <= stamp;
    end
    assign slots[k*TIME_W +: TIME_W] = slot_q[k];
  end

  p_ptr_range_r9: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);

  p_capture_store_r8: assert property (@(posedge clk) disable iff (rst)
    capture |=> (slot_q[$past(ptr_q)] == $past(stamp)));

  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (capture && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
  import stopwatch_pkg::*;
#(
  parameter int N_LAPS      = 4,
  parameter int HR_TENS_MAX = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_1s,
  input  logic                     run_toggle,
  input  logic                     lap_capture,
  output logic                     running,
  output logic [TIME_W-1:0]        time_bcd,
  output logic [N_LAPS*TIME_W-1:0] lap_bank
);
  logic   run_q;
  logic   sec_step;
  stamp_t now;

  always_ff @(posedge clk) begin
    if (rst)             run_q <= 1'b0;
    else if (run_toggle) run_q <= ~run_q;
  end

  // Tick counts only under the run state present before this edge
  assign sec_step = tick_1s && run_q;

  time_chain #(.HR_TENS_MAX(HR_TENS_MAX)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .advance (sec_step),
    .now     (now)
  );

  lap_bank #(.N_LAPS(N_LAPS)) u_laps (
    .clk     (clk),
    .rst     (rst),
    .capture (lap_capture),
    .stamp   (now),
    .slots   (lap_bank)
  );

  assign running  = run_q;
  assign time_bcd = now;

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    run_toggle |=> (running != $past(running)));

  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(time_bcd));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (time_bcd == '0 && lap_bank == '0 && !running));
endmodule

// File: tb/bcd_stopwatch_tb_top.sv
module bcd_stopwatch_tb_top;
  localparam int NL    = 4;
  localparam int HTM   = 1;
  localparam int HOURS = (HTM + 1) * 10;
  localparam int MAXT  = HOURS * 3600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, tog = 1'b0, cap = 1'b0;
  logic running;
  logic [23:0] time_bcd;
  logic [NL*24-1:0] lap_bank;

  always #2 clk = ~clk;

  bcd_stopwatch #(.N_LAPS(NL), .HR_TENS_MAX(HTM)) dut_i (
    .clk(clk), .rst(rst), .tick_1s(tick), .run_toggle(tog),
    .lap_capture(cap), .running(running), .time_bcd(time_bcd),
    .lap_bank(lap_bank)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_t = 0, m_ptr = 0;
  bit m_run = 0;
  int m_laps [NL];

  function automatic logic [23:0] to_bcd(input int t);
    int h, m, s;
    h = t / 3600; m = (t / 60) % 60; s = t % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  function automatic bit bcd_ok(input logic [23:0] v);
    return v[3:0] <= 9 && v[7:4] <= 5 && v[11:8] <= 9 && v[15:12] <= 5 &&
           v[19:16] <= 9 && v[23:20] <= 9;
  endfunction

  task automatic chk(input string tag, input string what, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [NL*24-1:0] el;
    for (int k = 0; k < NL; k++) el[k*24 +: 24] = to_bcd(m_laps[k]);
    chk(tag, "time", 96'(time_bcd), 96'(to_bcd(m_t)));
    chk(tag, "run", 96'(running), 96'(m_run));
    chk(tag, "laps", 96'(lap_bank), 96'(el));
  endtask

  task automatic step(input bit tk, input bit tg, input bit cp);
    @(negedge clk);
    tick = tk; tog = tg; cap = cp;
    @(posedge clk);
    if (cp) begin m_laps[m_ptr] = m_t; m_ptr = (m_ptr + 1) % NL; end
    if (tk && m_run) m_t = (m_t + 1) % MAXT;
    if (tg) m_run = !m_run;
    #1; tick = 0; tog = 0; cap = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    #1; rst = 0;
    m_t = 0; m_ptr = 0; m_run = 0;
    for (int k = 0; k < NL; k++) m_laps[k] = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    do_reset();
    chk_all("R1");
    ticks(5);
    chk("R3", "stopped hold", 96'(time_bcd), 96'(0));
    step(0, 1, 0);
    chk("R3", "toggle on", 96'(running), 96'(1));
    ticks(9);
    chk("R2", "nine ticks", 96'(time_bcd), 96'(24'h000009));
    ticks(1);
    chk("R4", "units wrap", 96'(time_bcd), 96'(24'h000010));
    ticks(49);
    chk("R4", "at 59", 96'(time_bcd), 96'(24'h000059));
    ticks(1);
    chk("R5", "sec roll", 96'(time_bcd), 96'(24'h000100));
    ticks(3540 - 1);
    chk("R6", "at 59:59", 96'(time_bcd), 96'(24'h005959));
    ticks(1);
    chk("R6", "min roll", 96'(time_bcd), 96'(24'h010000));
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    chk("R2", "idle hold", 96'(time_bcd), 96'(24'h010000));
    // lap rotation
    for (int i = 0; i < NL; i++) begin step(0, 0, 1); ticks(3); end
    chk_all("R8");
    chk("R8", "slot2", 96'(lap_bank[2*24 +: 24]), 96'(24'h010006));
    step(0, 0, 1);
    chk("R9", "slot0 overwritten", 96'(lap_bank[23:0]), 96'(24'h010012));
    chk("R9", "time untouched", 96'(time_bcd), 96'(24'h010012));
    step(1, 0, 1);
    chk("R10", "pre-increment lap", 96'(lap_bank[47:24]), 96'(24'h010012));
    chk("R10", "time advanced", 96'(time_bcd), 96'(24'h010013));
    step(1, 1, 0);
    chk("R11", "tick counts with old run", 96'(time_bcd), 96'(24'h010014));
    step(1, 1, 0);
    chk("R11", "tick ignored while stopped", 96'(time_bcd), 96'(24'h010014));
    chk_all("R11");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit tk, tg, cp;
      tk = ($urandom % 4) != 0;
      tg = ($urandom % 23) == 0;
      cp = ($urandom % 11) == 0;
      step(tk, tg, cp);
      if (i % 8 == 0) begin
        chk_all("R2");
        chk("R12", "bcd range", 96'(bcd_ok(time_bcd)), 96'(1));
      end
    end
    // reset returns pointer to slot 0
    do_reset();
    chk_all("R1");
    step(0, 1, 0); ticks(7); step(0, 0, 1);
    chk("R1", "first capture in slot 0", 96'(lap_bank[23:0]), 96'(24'h000007));
    chk_all("R1");
    // run to the final wrap
    while (m_t != MAXT - 1) step(1, 0, 0);
    chk("R7", "at max", 96'(time_bcd), 96'(to_bcd(MAXT - 1)));
    chk("R7", "max digits", 96'(time_bcd), 96'(24'h195959));
    step(1, 0, 0);
    chk("R7", "wrap to zero", 96'(time_bcd), 96'(0));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule